// File: doc/BRIEF.md
# CAN Controller Operating-Mode Sequencer

This block holds the operating mode of a CAN controller: asleep, initialising, running normally, or cut off from the bus after too many transmit errors. It watches the sampled receive bit, taken once per bit time when a strobe is high, and counts runs of recessive bits. A run of eleven recessive bits means the bus is idle. That condition lets the controller leave sleep. Bus-off recovery needs 128 such runs.

Software steers the block with two level requests, one for sleep and one for initialisation. Two configuration bits choose whether bus activity wakes the controller by itself and whether recovery from bus-off ends without software help. The transmit error counter comes from the error logic as an input. The block reports sleep and init acknowledges, a bus-off flag, and a one-cycle wakeup event. Mode encoding inside the block is private; the four outputs are the only view of it.

Top module: `can_mode_seq`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, sleep acknowledge is 1 and init acknowledge, bus-off and wakeup event are 0.
- R2: A receive bit of 1 is recessive and 0 is dominant. After the sleep request drops, sleep acknowledge stays 1 until 11 consecutive recessive bits are strobed. It reads 0 in the cycle after the eleventh strobe. The controller then enters initialisation if the init request is high, and normal mode otherwise.
- R3: A dominant strobed bit restarts the recessive run from zero, so 11 further recessive bits are needed.
- R4: Receive-bit values present while the bit strobe is low are neither counted nor allowed to break a run.
- R5: While asleep with the sleep request high, the controller stays asleep whatever the init request and recessive bits do; initialisation is reached from sleep only after the sleep request is cleared.
- R6: Init acknowledge rises on the first bit strobe taken in initialisation, not on entry. It falls one clock after the mode leaves initialisation.
- R7: In normal mode, a transmit error count above 255 sets bus-off in the next cycle; 255 does not. Bus-off entry wins over an init request made in the same cycle.
- R8: With automatic recovery set, the controller leaves bus-off for normal mode one cycle after the 128th run of 11 recessive bits is complete; 127 runs are not enough.
- R9: With automatic recovery clear, an init request during bus-off is ignored until 128 runs have been seen. After that an init request moves the controller into initialisation.
- R10: A dominant strobed bit while asleep gives a one-cycle wakeup event in the next cycle. With automatic wakeup set, the controller also goes to normal mode; otherwise it stays asleep.
- R11: After an automatic wakeup, a sleep request that is still high is ignored until it has been seen low.
- R12: In normal mode a sleep request enters sleep in the next cycle; if the init request is also high, initialisation is entered instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_bit | input | 1 | Sampled receive bit, 1 = recessive |
| bit_stb | input | 1 | One-cycle strobe per bit time |
| req_sleep | input | 1 | Software sleep request (level) |
| req_init | input | 1 | Software initialisation request (level) |
| cfg_auto_wake | input | 1 | Bus activity wakes the controller |
| cfg_auto_recov | input | 1 | Bus-off recovery ends without software |
| tx_err_cnt | input | 9 | Transmit error counter value |
| ack_sleep | output | 1 | Sleep acknowledge |
| ack_init | output | 1 | Initialisation acknowledge |
| bus_off | output | 1 | Controller is in bus-off |
| wake_evt | output | 1 | One-cycle pulse on bus activity while asleep |

## Verification
Two pairs of events can land on the same clock edge. The first is the error count crossing the bus-off threshold in the same cycle that software raises the init request. The bench drives both at one negative edge and expects bus-off with no init acknowledge, even after a later bit strobe. The second is the 128th recovery run finishing while an init request is pending in manual mode. The bench shows that a request made before that run is dropped and that one made after it is honoured.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  typedef enum logic [1:0] {
    MD_SLEEP  = 2'd0,
    MD_INIT   = 2'd1,
    MD_NORMAL = 2'd2,
    MD_BUSOFF = 2'd3
  } mode_e;

endpackage

// File: rtl/cm_run_counter.sv
module cm_run_counter #(
  parameter int IDLE_LEN = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic stb_i,
  input  logic rx_i,
  output logic idle_pulse_o
);
  localparam int RUN_W = $clog2(IDLE_LEN + 1);

  logic [RUN_W-1:0] cnt_q;

  function automatic logic [RUN_W-1:0] run_step(input logic [RUN_W-1:0] cnt,
                                                input logic rx);
    if (!rx) return '0;
    if (cnt == RUN_W'(IDLE_LEN - 1)) return '0;
    return cnt + 1'b1;
  endfunction

  assign idle_pulse_o = !clr_i && stb_i && rx_i && (cnt_q == RUN_W'(IDLE_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (stb_i)   cnt_q <= run_step(cnt_q, rx_i);
  end

  // R3
  dominant_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !rx_i && !clr_i) |=> (cnt_q == '0));

  // R4
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_i && !clr_i) |=> $stable(cnt_q));

endmodule

// File: rtl/cm_occ_counter.sv
module cm_occ_counter #(
  parameter int RECOV_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic pulse_i,
  output logic done_o
);
  localparam int OCC_W = $clog2(RECOV_RUNS + 1);

  logic [OCC_W-1:0] occ_q;

  function automatic logic [OCC_W-1:0] occ_step(input logic [OCC_W-1:0] cnt);
    if (cnt == OCC_W'(RECOV_RUNS)) return cnt;
    return cnt + 1'b1;
  endfunction

  assign done_o = (occ_q == OCC_W'(RECOV_RUNS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        occ_q <= '0;
    else if (clr_i)    occ_q <= '0;
    else if (pulse_i)  occ_q <= occ_step(occ_q);
  end

  // R8
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(pulse_i));

endmodule

// File: rtl/cm_mode_fsm.sv
module cm_mode_fsm
  import can_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_sleep,
  input  logic  req_init,
  input  logic  cfg_auto_wake,
  input  logic  cfg_auto_recov,
  input  logic  tec_over,
  input  logic  idle_pulse,
  input  logic  dom_strobe,
  input  logic  recov_done,
  input  logic  bit_stb,
  output mode_e mode_q,
  output logic  ack_init_q,
  output logic  wake_evt_q
);
  mode_e mode_d;
  logic  wake_lock_q;
  logic  sleep_ok;
  logic  auto_wake_go;
  logic  idle_exit;

  assign sleep_ok     = req_sleep && !wake_lock_q;
  assign auto_wake_go = (mode_q == MD_SLEEP) && dom_strobe && cfg_auto_wake;
  assign idle_exit    = (mode_q == MD_SLEEP) && !req_sleep && idle_pulse;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      MD_SLEEP: begin
        if (auto_wake_go)   mode_d = MD_NORMAL;
        else if (idle_exit) mode_d = req_init ? MD_INIT : MD_NORMAL;
      end
      MD_INIT: begin
        if (!req_init) mode_d = sleep_ok ? MD_SLEEP : MD_NORMAL;
      end
      MD_NORMAL: begin
        if (tec_over)      mode_d = MD_BUSOFF;
        else if (req_init) mode_d = MD_INIT;
        else if (sleep_ok) mode_d = MD_SLEEP;
      end
      MD_BUSOFF: begin
        if (recov_done && cfg_auto_recov) mode_d = MD_NORMAL;
        else if (recov_done && req_init)  mode_d = MD_INIT;
      end
      default: mode_d = MD_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MD_SLEEP;
      ack_init_q  <= 1'b0;
      wake_evt_q  <= 1'b0;
      wake_lock_q <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      ack_init_q <= (mode_q == MD_INIT) && (ack_init_q || bit_stb);
      wake_evt_q <= (mode_q == MD_SLEEP) && dom_strobe;
      if (!req_sleep)        wake_lock_q <= 1'b0;
      else if (auto_wake_go) wake_lock_q <= 1'b1;
    end
  end

  // R2
  sleep_exit_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_SLEEP && $past(mode_q) == MD_SLEEP) |->
      $past(idle_pulse || (dom_strobe && cfg_auto_wake)));

  // R5
  sleep_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SLEEP && req_sleep && !(dom_strobe && cfg_auto_wake)) |=>
      (mode_q == MD_SLEEP));

  // R6
  init_ack_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_init_q |-> (mode_q == MD_INIT || $past(mode_q) == MD_INIT));

  // R7
  busoff_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_NORMAL && tec_over) |=> (mode_q == MD_BUSOFF));

  // R9
  busoff_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MD_BUSOFF && $past(mode_q) == MD_BUSOFF) |-> $past(recov_done));

  // R10
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt_q |-> $past(mode_q == MD_SLEEP && dom_strobe));

  // R11
  wake_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_NORMAL && wake_lock_q && !tec_over && !req_init) |=>
      (mode_q == MD_NORMAL));

endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int IDLE_LEN   = 11,
  parameter int RECOV_RUNS = 128,
  parameter int TEC_W      = 9,
  parameter int TEC_LIMIT  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             bit_stb,
  input  logic             req_sleep,
  input  logic             req_init,
  input  logic             cfg_auto_wake,
  input  logic             cfg_auto_recov,
  input  logic [TEC_W-1:0] tx_err_cnt,
  output logic             ack_sleep,
  output logic             ack_init,
  output logic             bus_off,
  output logic             wake_evt
);
  function automatic logic tec_exceeds(input logic [TEC_W-1:0] tec);
    return tec > TEC_W'(TEC_LIMIT);
  endfunction

  mode_e mode_q;
  logic  tec_over;
  logic  dom_strobe;
  logic  idle_pulse;
  logic  recov_done;
  logic  run_clr;
  logic  occ_clr;

  assign tec_over   = tec_exceeds(tx_err_cnt);
  assign dom_strobe = bit_stb && !rx_bit;
  assign run_clr    = !(((mode_q == MD_SLEEP) && !req_sleep) || (mode_q == MD_BUSOFF));
  assign occ_clr    = (mode_q != MD_BUSOFF);

  cm_run_counter #(.IDLE_LEN(IDLE_LEN)) u_run (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (run_clr),
    .stb_i        (bit_stb),
    .rx_i         (rx_bit),
    .idle_pulse_o (idle_pulse)
  );

  cm_occ_counter #(.RECOV_RUNS(RECOV_RUNS)) u_occ (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (occ_clr),
    .pulse_i (idle_pulse),
    .done_o  (recov_done)
  );

  cm_mode_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_sleep      (req_sleep),
    .req_init       (req_init),
    .cfg_auto_wake  (cfg_auto_wake),
    .cfg_auto_recov (cfg_auto_recov),
    .tec_over       (tec_over),
    .idle_pulse     (idle_pulse),
    .dom_strobe     (dom_strobe),
    .recov_done     (recov_done),
    .bit_stb        (bit_stb),
    .mode_q         (mode_q),
    .ack_init_q     (ack_init),
    .wake_evt_q     (wake_evt)
  );

  assign ack_sleep = (mode_q == MD_SLEEP);
  assign bus_off   = (mode_q == MD_BUSOFF);

  // R1
  reset_outputs_chk: assert property (@(posedge clk)
    !rst_n |=> (ack_sleep && !ack_init && !bus_off && !wake_evt));

endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RUN        = 11;
  localparam int RUNS       = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b1;
  logic       bit_stb = 1'b0;
  logic       req_sleep = 1'b1;
  logic       req_init = 1'b0;
  logic       cfg_auto_wake = 1'b0;
  logic       cfg_auto_recov = 1'b0;
  logic [8:0] tx_err_cnt = '0;
  logic       ack_sleep, ack_init, bus_off, wake_evt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .bit_stb(bit_stb),
    .req_sleep(req_sleep), .req_init(req_init),
    .cfg_auto_wake(cfg_auto_wake), .cfg_auto_recov(cfg_auto_recov),
    .tx_err_cnt(tx_err_cnt), .ack_sleep(ack_sleep), .ack_init(ack_init),
    .bus_off(bus_off), .wake_evt(wake_evt)
  );

  task automatic check(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobe(input logic b);
    rx_bit  = b;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    rx_bit  = 1'b1;
  endtask

  task automatic rec_bits(input int n);
    for (int i = 0; i < n; i++) strobe(1'b1);
  endtask

  task automatic t_reset();
    check("R1 ack_sleep in reset", ack_sleep, 1'b1);
    check("R1 bus_off in reset", bus_off, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R1 ack_sleep after reset", ack_sleep, 1'b1);
    check("R1 ack_init after reset", ack_init, 1'b0);
    check("R1 wake_evt after reset", wake_evt, 1'b0);
  endtask

  task automatic t_sleep_exit();
    req_sleep = 1'b0;
    tick();
    rec_bits(5);
    rx_bit = 1'b0;
    repeat (3) tick();
    rx_bit = 1'b1;
    rec_bits(5);
    check("R4 unstrobed zeros ignored, still asleep", ack_sleep, 1'b1);
    strobe(1'b1);
    check("R2 sleep left after 11th recessive", ack_sleep, 1'b0);
    check("R2 normal entered, no init ack", ack_init, 1'b0);
  endtask

  task automatic t_dominant_restart();
    req_sleep = 1'b1;
    tick();
    check("R12 sleep entered from normal", ack_sleep, 1'b1);
    req_sleep = 1'b0;
    rec_bits(10);
    strobe(1'b0);
    check("R10 wake event after dominant", wake_evt, 1'b1);
    check("R10 no auto wake stays asleep", ack_sleep, 1'b1);
    tick();
    check("R10 wake event one cycle", wake_evt, 1'b0);
    rec_bits(10);
    check("R3 run restarted by dominant", ack_sleep, 1'b1);
    strobe(1'b1);
    check("R3 exit after fresh 11 bits", ack_sleep, 1'b0);
  endtask

  task automatic t_init_from_sleep();
    req_sleep = 1'b1;
    tick();
    req_init = 1'b1;
    rec_bits(15);
    check("R5 init blocked while sleep requested", ack_sleep, 1'b1);
    check("R5 no init ack while asleep", ack_init, 1'b0);
    req_sleep = 1'b0;
    rec_bits(RUN);
    check("R2 sleep left toward init", ack_sleep, 1'b0);
    check("R6 init ack not set on entry", ack_init, 1'b0);
    strobe(1'b1);
    check("R6 init ack on first strobe", ack_init, 1'b1);
    req_init = 1'b0;
    tick();
    check("R6 init ack held in leaving cycle", ack_init, 1'b1);
    tick();
    check("R6 init ack cleared one clock later", ack_init, 1'b0);
  endtask

  task automatic t_busoff_priority();
    tx_err_cnt = 9'd255;
    tick();
    check("R7 count 255 not bus-off", bus_off, 1'b0);
    tx_err_cnt = 9'd256;
    req_init   = 1'b1;
    tick();
    check("R7 bus-off over init request", bus_off, 1'b1);
    strobe(1'b1);
    check("R7 no init ack in bus-off", ack_init, 1'b0);
    req_init   = 1'b0;
    tx_err_cnt = '0;
  endtask

  task automatic t_auto_recovery();
    cfg_auto_recov = 1'b1;
    rec_bits(RUN * (RUNS - 1) - 1);
    check("R8 127 runs not enough", bus_off, 1'b1);
    rec_bits(RUN);
    check("R8 still bus-off on last strobe", bus_off, 1'b1);
    tick();
    check("R8 auto recovery to normal", bus_off, 1'b0);
    check("R8 recovery lands in normal", ack_sleep, 1'b0);
  endtask

  task automatic t_manual_recovery();
    cfg_auto_recov = 1'b0;
    tx_err_cnt = 9'd300;
    tick();
    check("R7 bus-off from count 300", bus_off, 1'b1);
    tx_err_cnt = '0;
    rec_bits(RUN * (RUNS - 1));
    req_init = 1'b1;
    tick();
    check("R9 early init request ignored", bus_off, 1'b1);
    req_init = 1'b0;
    rec_bits(RUN);
    tick();
    check("R9 no exit without request", bus_off, 1'b1);
    req_init = 1'b1;
    tick();
    check("R9 request honoured after recovery", bus_off, 1'b0);
    strobe(1'b1);
    check("R9 init ack after recovery", ack_init, 1'b1);
    req_init = 1'b0;
    tick();
    tick();
    check("R9 back to normal", ack_init, 1'b0);
  endtask

  task automatic t_auto_wake();
    cfg_auto_wake = 1'b1;
    req_sleep = 1'b1;
    tick();
    check("R12 asleep again", ack_sleep, 1'b1);
    strobe(1'b0);
    check("R10 auto wake leaves sleep", ack_sleep, 1'b0);
    check("R10 wake event on auto wake", wake_evt, 1'b1);
    repeat (3) tick();
    check("R11 held sleep request ignored", ack_sleep, 1'b0);
    req_sleep = 1'b0;
    tick();
    req_sleep = 1'b1;
    tick();
    check("R11 fresh sleep request honoured", ack_sleep, 1'b1);
    strobe(1'b0);
    req_sleep = 1'b0;
    tick();
    req_sleep = 1'b1;
    req_init  = 1'b1;
    tick();
    check("R12 init wins over sleep", ack_sleep, 1'b0);
    strobe(1'b1);
    check("R12 init entered", ack_init, 1'b1);
    req_init = 1'b0;
    req_sleep = 1'b0;
  endtask

  initial begin
    repeat (3) tick();
    t_reset();
    t_sleep_exit();
    t_dominant_restart();
    t_init_from_sleep();
    t_busoff_priority();
    t_auto_recovery();
    t_manual_recovery();
    t_auto_wake();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule